// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write-side steering logic of a 32-queue buffer with an 18-bit data word. It can sit in a cascade of up to eight such buffers that share one address bus. On every rising write clock it decodes a shared 8-bit address bus. The three upper bits name the target device and are compared against a strapped identity. The five lower bits either choose the queue that later writes go to, or, on a flag strobe, choose which group of eight queues shows its almost-full flags on an 8-bit flag bus.

A queue change does not take effect at once. Writes keep landing in the previously chosen queue on the edge that captures the new address and on the edge after it. From the second edge onward they go to the new queue. Each accepted write comes out as a registered write strobe, queue index and data word, which drive the queue storage.

Top module: `mq_wsel`

## Requirements
- R1: After reset, and after any later reset, `mem_we` is low and `paf_bus` is all ones (8'hFF). Writes are dropped until the first matching queue select has taken effect.
- R2: A queue select is captured on a rising edge only when `addr_en` is high and `wr_addr[7:5]` equals `dev_id`. `wr_addr[4:0]` then gives the queue index, 0 to 31.
- R3: On the capture edge and on the next rising edge, a write (`wr_en_n` low) still goes to the previously selected queue.
- R4: From the second rising edge after a capture, writes go to the new queue. Two selects on consecutive edges each take effect two edges after their own capture.
- R5: A write is accepted on an edge where `wr_en_n` is low. After that edge `mem_we` is high and `mem_qidx`/`mem_wdata` carry the queue and `din`. When `wr_en_n` is high, `mem_we` is low after that edge.
- R6: A flag strobe (`flag_strobe` high, `addr_en` low, ID matching) selects quadrant n = `wr_addr[1:0]`, and `wr_addr[4:2]` is ignored. From the second edge after the strobe, `paf_bus[k]` shows `q_flags[8n+k]`, sampled one edge earlier, so flag changes appear after one edge.
- R7: A write on the same edge as a quadrant selection goes to the current queue.
- R8: A queue select whose ID does not match deselects this device: writes are dropped from the second edge on. A non-matching flag strobe drives `paf_bus` to all ones from the second edge on.
- R9: When `addr_en` and `flag_strobe` are both high, only the queue select acts and the selected quadrant is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 3 | Strapped cascade identity |
| wr_addr | input | 8 | Shared address bus: [7:5] device, [4:0] queue or [1:0] quadrant |
| addr_en | input | 1 | Queue-select capture enable, active high |
| flag_strobe | input | 1 | Quadrant-select strobe, active high |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | 18 | Write data |
| q_flags | input | 32 | Per-queue almost-full flags, active low, bit i = queue i |
| mem_we | output | 1 | Registered write strobe to queue storage |
| mem_qidx | output | 5 | Registered target queue index |
| mem_wdata | output | 18 | Registered write data |
| paf_bus | output | 8 | Registered almost-full flags of the selected quadrant, all ones when idle |

## Verification
A wrong pending or active queue register shows up as a wrong `mem_qidx` on the first write of the third cycle after a select, or as a write that should have been dropped. It is therefore visible within three edges of the select that exposes it. A fault in the quadrant register or the identity filter shows on `paf_bus` two edges after the strobe. The strobe pattern is built so that the four quadrant values differ in every position.

// File: rtl/mq_wsel_pkg.sv
package mq_wsel_pkg;

  // Operation decoded from the shared address bus on one edge
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_QSEL = 2'd1,
    OP_QUAD = 2'd2
  } addr_op_e;

  // Queue select wins over a quadrant strobe on the same edge
  function automatic addr_op_e decode_op(input logic aen, input logic fstr);
    if (aen)       return OP_QSEL;
    else if (fstr) return OP_QUAD;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/mq_addr_decode.sv
module mq_addr_decode
  import mq_wsel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  parameter int QIDX_W = 5,
  parameter int QUAD_W = 2
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              addr_en,
  input  logic              flag_strobe,
  output addr_op_e          op,
  output logic              id_hit,
  output logic [QIDX_W-1:0] qidx,
  output logic [QUAD_W-1:0] quad
);

  localparam int ID_LSB = ADDR_W - ID_W;

  always_comb begin
    op     = decode_op(addr_en, flag_strobe);
    id_hit = (wr_addr[ADDR_W-1:ID_LSB] == dev_id);
    qidx   = wr_addr[QIDX_W-1:0];
    quad   = wr_addr[QUAD_W-1:0];
  end

endmodule

// File: rtl/mq_qsel_pipe.sv
module mq_qsel_pipe
  import mq_wsel_pkg::*;
#(
  parameter int QIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_op_e          op,
  input  logic              id_hit,
  input  logic [QIDX_W-1:0] qidx,
  output logic              act_valid,
  output logic [QIDX_W-1:0] act_idx
);

  // Stage 1: captured select; stage 2: select in force for writes
  logic              pend_v;
  logic              pend_hit;
  logic [QIDX_W-1:0] pend_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_hit  <= 1'b0;
      pend_idx  <= '0;
      act_valid <= 1'b0;
      act_idx   <= '0;
    end else begin
      pend_v <= (op == OP_QSEL);
      if (op == OP_QSEL) begin
        pend_hit <= id_hit;
        pend_idx <= qidx;
      end
      if (pend_v) begin
        act_valid <= pend_hit;
        act_idx   <= pend_idx;
      end
    end
  end

endmodule

// File: rtl/mq_write_steer.sv
module mq_write_steer #(
  parameter int DATA_W = 18,
  parameter int QIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_valid,
  input  logic [QIDX_W-1:0] act_idx,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  output logic              mem_we,
  output logic [QIDX_W-1:0] mem_qidx,
  output logic [DATA_W-1:0] mem_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_qidx  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= act_valid && !wr_en_n;
      mem_qidx  <= act_idx;
      mem_wdata <= din;
    end
  end

endmodule

// File: rtl/mq_flag_mux.sv
module mq_flag_mux
  import mq_wsel_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int FLAG_W     = 8,
  parameter int QUAD_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  addr_op_e              op,
  input  logic                  id_hit,
  input  logic [QUAD_W-1:0]     quad,
  input  logic [NUM_QUEUES-1:0] q_flags,
  output logic [FLAG_W-1:0]     paf_bus
);

  localparam int NUM_QUADS = NUM_QUEUES / FLAG_W;

  logic [FLAG_W-1:0] slice [NUM_QUADS];
  logic              quad_v;
  logic [QUAD_W-1:0] quad_r;

  for (genvar g = 0; g < NUM_QUADS; g++) begin : g_slice
    assign slice[g] = q_flags[g*FLAG_W +: FLAG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_v  <= 1'b0;
      quad_r  <= '0;
      paf_bus <= '1;
    end else begin
      if (op == OP_QUAD) begin
        quad_v <= id_hit;
        quad_r <= quad;
      end
      paf_bus <= quad_v ? slice[quad_r] : '1;
    end
  end

endmodule

// File: rtl/mq_wsel.sv
module mq_wsel
  import mq_wsel_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 8,
  parameter int ID_W       = 3,
  parameter int FLAG_W     = 8,
  parameter int QIDX_W     = $clog2(NUM_QUEUES),
  parameter int QUAD_W     = $clog2(NUM_QUEUES / FLAG_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ID_W-1:0]       dev_id,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic                  addr_en,
  input  logic                  flag_strobe,
  input  logic                  wr_en_n,
  input  logic [DATA_W-1:0]     din,
  input  logic [NUM_QUEUES-1:0] q_flags,
  output logic                  mem_we,
  output logic [QIDX_W-1:0]     mem_qidx,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [FLAG_W-1:0]     paf_bus
);

  addr_op_e          op;
  logic              id_hit;
  logic [QIDX_W-1:0] qidx;
  logic [QUAD_W-1:0] quad;
  logic              act_valid;
  logic [QIDX_W-1:0] act_idx;

  mq_addr_decode #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .QIDX_W(QIDX_W), .QUAD_W(QUAD_W)
  ) u_dec (
    .wr_addr(wr_addr), .dev_id(dev_id), .addr_en(addr_en),
    .flag_strobe(flag_strobe), .op(op), .id_hit(id_hit),
    .qidx(qidx), .quad(quad)
  );

  mq_qsel_pipe #(.QIDX_W(QIDX_W)) u_pipe (
    .clk(clk), .rst(rst), .op(op), .id_hit(id_hit), .qidx(qidx),
    .act_valid(act_valid), .act_idx(act_idx)
  );

  mq_write_steer #(.DATA_W(DATA_W), .QIDX_W(QIDX_W)) u_steer (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_idx(act_idx),
    .wr_en_n(wr_en_n), .din(din), .mem_we(mem_we),
    .mem_qidx(mem_qidx), .mem_wdata(mem_wdata)
  );

  mq_flag_mux #(
    .NUM_QUEUES(NUM_QUEUES), .FLAG_W(FLAG_W), .QUAD_W(QUAD_W)
  ) u_flag (
    .clk(clk), .rst(rst), .op(op), .id_hit(id_hit), .quad(quad),
    .q_flags(q_flags), .paf_bus(paf_bus)
  );

endmodule

// File: rtl/mq_wsel_chk.sv
module mq_wsel_chk #(
  parameter int NUM_QUEUES = 32,
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 8,
  parameter int ID_W       = 3,
  parameter int FLAG_W     = 8,
  parameter int QIDX_W     = $clog2(NUM_QUEUES),
  parameter int QUAD_W     = $clog2(NUM_QUEUES / FLAG_W)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ID_W-1:0]       dev_id,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic                  addr_en,
  input logic                  flag_strobe,
  input logic                  wr_en_n,
  input logic [DATA_W-1:0]     din,
  input logic [NUM_QUEUES-1:0] q_flags,
  input logic                  mem_we,
  input logic [QIDX_W-1:0]     mem_qidx,
  input logic [DATA_W-1:0]     mem_wdata,
  input logic [FLAG_W-1:0]     paf_bus
);

  logic [1:0] up_cnt;
  logic       hit;

  assign hit = (wr_addr[ADDR_W-1 -: ID_W] == dev_id);

  always_ff @(posedge clk) begin
    if (rst)               up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  function automatic logic [FLAG_W-1:0] pick(input logic [NUM_QUEUES-1:0] f,
                                             input logic [QUAD_W-1:0] q);
    return f[q*FLAG_W +: FLAG_W];
  endfunction

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && paf_bus == '1));

  p_no_write_when_high_r5: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en_n) |-> !mem_we);

  p_write_data_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == $past(din));

  p_new_queue_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && $past(addr_en && hit, 3) && mem_we)
      |-> mem_qidx == $past(wr_addr[QIDX_W-1:0], 3));

  p_quadrant_view_r6: assert property (@(posedge clk) disable iff (rst)
    (up_cnt >= 2'd2 && $past(flag_strobe && !addr_en && hit, 2))
      |-> paf_bus == pick($past(q_flags), $past(wr_addr[QUAD_W-1:0], 2)));

  p_foreign_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (up_cnt >= 2'd2 && $past(flag_strobe && !addr_en && !hit, 2))
      |-> paf_bus == '1);

endmodule

bind mq_wsel mq_wsel_chk #(
  .NUM_QUEUES(NUM_QUEUES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .ID_W(ID_W), .FLAG_W(FLAG_W), .QIDX_W(QIDX_W), .QUAD_W(QUAD_W)
) u_chk (
  .clk(clk), .rst(rst), .dev_id(dev_id), .wr_addr(wr_addr),
  .addr_en(addr_en), .flag_strobe(flag_strobe), .wr_en_n(wr_en_n),
  .din(din), .q_flags(q_flags), .mem_we(mem_we), .mem_qidx(mem_qidx),
  .mem_wdata(mem_wdata), .paf_bus(paf_bus)
);

// File: tb/tb_mq_wsel.sv
module tb_mq_wsel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  dev_id = 3'd5;
  logic [7:0]  wr_addr = '0;
  logic        addr_en = 1'b0;
  logic        flag_strobe = 1'b0;
  logic        wr_en_n = 1'b1;
  logic [17:0] din = '0;
  logic [31:0] q_flags = 32'hA5C3_3C5A;
  logic        mem_we;
  logic [4:0]  mem_qidx;
  logic [17:0] mem_wdata;
  logic [7:0]  paf_bus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mq_wsel dut (
    .clk(clk), .rst(rst), .dev_id(dev_id), .wr_addr(wr_addr),
    .addr_en(addr_en), .flag_strobe(flag_strobe), .wr_en_n(wr_en_n),
    .din(din), .q_flags(q_flags), .mem_we(mem_we), .mem_qidx(mem_qidx),
    .mem_wdata(mem_wdata), .paf_bus(paf_bus)
  );

  typedef struct packed {
    bit        aen;
    bit        fs;
    bit        wen_n;
    bit [7:0]  addr;
    bit [17:0] data;
    bit        ewe;
    bit [4:0]  eq;
    bit [7:0]  epaf;
  } vec_t;

  // Device id 5 => addr[7:5] = 3'b101 (0xA0..0xBF)
  localparam vec_t VEC [23] = '{
    '{1'b1, 1'b0, 1'b0, 8'hA3, 18'h1,  1'b0, 5'd0,  8'hFF}, // R1 select q3, none active
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h2,  1'b0, 5'd0,  8'hFF}, // R1 still dropped
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h3,  1'b1, 5'd3,  8'hFF}, // R2 q3 in force
    '{1'b1, 1'b0, 1'b0, 8'hB1, 18'h4,  1'b1, 5'd3,  8'hFF}, // R3 capture edge old q
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h5,  1'b1, 5'd3,  8'hFF}, // R3 next edge old q
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h6,  1'b1, 5'd17, 8'hFF}, // R4 new q17
    '{1'b0, 1'b0, 1'b1, 8'h00, 18'h7,  1'b0, 5'd0,  8'hFF}, // R5 wen_n high
    '{1'b0, 1'b1, 1'b0, 8'hBD, 18'h8,  1'b1, 5'd17, 8'hFF}, // R7 write + quad1, [4:2] junk
    '{1'b0, 1'b0, 1'b1, 8'h00, 18'h0,  1'b0, 5'd0,  8'h3C}, // R6 quad1 shown
    '{1'b1, 1'b0, 1'b0, 8'h62, 18'h9,  1'b1, 5'd17, 8'h3C}, // R8 foreign select
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'hA,  1'b1, 5'd17, 8'h3C}, // R8 still old
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'hB,  1'b0, 5'd0,  8'h3C}, // R8 deselected
    '{1'b1, 1'b1, 1'b1, 8'hA6, 18'h0,  1'b0, 5'd0,  8'h3C}, // R9 both high
    '{1'b0, 1'b0, 1'b1, 8'h00, 18'h0,  1'b0, 5'd0,  8'h3C}, // R9 quad kept
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'hC,  1'b1, 5'd6,  8'h3C}, // R9 queue select acted
    '{1'b0, 1'b1, 1'b0, 8'h43, 18'hD,  1'b1, 5'd6,  8'h3C}, // R8 foreign strobe
    '{1'b0, 1'b0, 1'b1, 8'h00, 18'h0,  1'b0, 5'd0,  8'hFF}, // R8 bus idle
    '{1'b0, 1'b1, 1'b1, 8'hA2, 18'h0,  1'b0, 5'd0,  8'hFF}, // R6 strobe quad2
    '{1'b0, 1'b0, 1'b1, 8'h00, 18'h0,  1'b0, 5'd0,  8'hC3}, // R6 quad2 shown
    '{1'b1, 1'b0, 1'b0, 8'hA0, 18'hE,  1'b1, 5'd6,  8'hC3}, // R4 b2b first q0
    '{1'b1, 1'b0, 1'b0, 8'hBF, 18'hF,  1'b1, 5'd6,  8'hC3}, // R4 b2b second q31
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h10, 1'b1, 5'd0,  8'hC3}, // R4 q0
    '{1'b0, 1'b0, 1'b0, 8'h00, 18'h11, 1'b1, 5'd31, 8'hC3}  // R4 q31
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit aen, input bit fs, input bit wen_n_i,
                      input bit [7:0] a, input bit [17:0] d);
    @(negedge clk);
    addr_en = aen; flag_strobe = fs; wr_en_n = wen_n_i; wr_addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset mem_we", {31'd0, mem_we}, 32'd0);
    chk("R1 reset paf_bus", {24'd0, paf_bus}, 32'hFF);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 23; i++) begin
      step(VEC[i].aen, VEC[i].fs, VEC[i].wen_n, VEC[i].addr, VEC[i].data);
      chk($sformatf("R5 row %0d mem_we", i), {31'd0, mem_we}, {31'd0, VEC[i].ewe});
      if (VEC[i].ewe) begin
        chk($sformatf("R4 row %0d mem_qidx", i), {27'd0, mem_qidx}, {27'd0, VEC[i].eq});
        chk($sformatf("R5 row %0d mem_wdata", i), {14'd0, mem_wdata}, {14'd0, VEC[i].data});
      end
      chk($sformatf("R6 row %0d paf_bus", i), {24'd0, paf_bus}, {24'd0, VEC[i].epaf});
    end

    // R6: flag change on selected quadrant 2 appears after one edge
    @(negedge clk);
    q_flags[23:16] = 8'h0F;
    step(1'b0, 1'b0, 1'b1, 8'h00, 18'h0);
    chk("R6 flag update", {24'd0, paf_bus}, 32'h0F);

    // R1: reset in mid operation clears queue and quadrant
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 8'h00, 18'h15);
    chk("R1 write dropped after reset", {31'd0, mem_we}, 32'd0);
    chk("R1 paf idle after reset", {24'd0, paf_bus}, 32'hFF);

    // R2: select with matching id but addr_en low does nothing
    step(1'b0, 1'b0, 1'b0, 8'hA4, 18'h16);
    step(1'b0, 1'b0, 1'b0, 8'h00, 18'h17);
    step(1'b0, 1'b0, 1'b0, 8'h00, 18'h18);
    chk("R2 no capture without addr_en", {31'd0, mem_we}, 32'd0);

    step(1'b0, 1'b0, 1'b1, 8'h00, 18'h0);
    finish_run();
  end

endmodule